// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block gathers interrupt requests from edge-signalled hardware lines, from per-core private sources and from software commands. It decides, independently for each of four cores, which enabled pending interrupt that core should take next, and hands it over through a claim/complete handshake. Each interrupt has a small state record with three states: idle, waiting, and in service. The record can also be in service and waiting at once.

The identifier space has three parts. IDs 0–15 are software interrupts. Each core holds its own copy of them, so one command can raise them on several cores. IDs 29 and 30 are each core's own timer and watchdog inputs. IDs 32–63 are shared hardware lines. Each shared line carries a target set, which is written as one core, a chosen group of cores, or every core. A write port sets up an interrupt's enable and priority, or its route, or issues a software command. Enables and priorities for IDs below 32 are held per core, and the issuing core is named on the write. A core reads its claim value in the same cycle that it asserts its claim strobe. It signals completion by writing the ID back.

Top module: `mp_irq_distributor`

## Requirements
- R1: After reset no core request is raised, and every claim value reads the idle code 1023.
- R2: A rising edge on a shared line makes that ID waiting. A disabled ID stays waiting but is not offered. Enabling it later offers it.
- R3: A shared ID is offered only to the cores in its target set. Route write fields are: mode in bits [1:0] (0 one core, 1 group, 2 all, 3 ignored), core index in bits [5:4], group mask in bits [11:8]. After reset every shared ID targets core 0.
- R4: Each core is offered the waiting, enabled, not-in-service ID with the smallest priority value. On equal priority the lower ID wins. The configuration write uses address [7:6]=0 and [5:0]=ID, with enable in bit 0 and priority in bits [7:4].
- R5: A claim returns the offered ID in the same cycle and moves that ID from waiting to in service. The core is then offered its next candidate, or 1023.
- R6: A completion write of an in-service ID returns it to idle. If the line rose again while the ID was in service, completion returns it to waiting, and it is offered again. An ID that is in service is never offered.
- R7: A software command uses address [7:6]=2. It carries the ID in bits [3:0], a listed core in bits [5:4] and a filter in bits [9:8]. Filter 0 selects the listed core, 1 selects all cores except the issuer, and 2 selects the issuer alone. Only the selected cores' private copies become waiting.
- R8: A software interrupt is ranked with the priority and enable held by the core it targets. The issuing core's settings play no part.
- R9: Private input 2c raises ID 29 and input 2c+1 raises ID 30, on core c only.
- R10: When several cores claim the same shared ID in one cycle, the lowest-numbered core gets it. The others read 1023 in that cycle and are not given the ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | 32 | Shared lines for IDs 32–63, rising-edge sensitive |
| priv_irq | input | 8 | Per-core timer (2c) and watchdog (2c+1) inputs |
| cfg_we | input | 1 | Write strobe of the setup port |
| cfg_core | input | 2 | Issuing core of the write |
| cfg_addr | input | 8 | Kind in [7:6], ID in [5:0] |
| cfg_wdata | input | 12 | Write data |
| ack_rd | input | 4 | Per-core claim strobe |
| eoi_wr | input | 4 | Per-core completion strobe |
| eoi_id | input | 40 | Per-core completed ID, 10 bits per core |
| ack_id | output | 40 | Per-core claim value, 10 bits per core |
| irq_req | output | 4 | Per-core request |

## Verification
Two cores can claim the same shared ID in the same cycle. The bench routes one line to cores 1 and 3 and raises both claim strobes together. It then checks that core 1 reads the ID, core 3 reads 1023, and afterwards neither is offered it. A line can also rise again while its ID is in service. The bench provokes this on an all-cores ID and checks that the ID is offered to no core until completion, and that it is offered again after completion.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int ID_W   = 10;
   localparam logic [ID_W-1:0] SPURIOUS = 10'd1023;
   localparam int BANK_N = 32;
   localparam int BW     = 5;
   localparam int ID_TMR = 29;
   localparam int ID_WDG = 30;

   typedef enum logic [1:0] {K_CFG = 2'd0, K_ROUTE = 2'd1, K_SGI = 2'd2, K_NONE = 2'd3} kind_e;
   typedef enum logic [1:0] {R_ONE = 2'd0, R_GROUP = 2'd1, R_ALL = 2'd2, R_NONE = 2'd3} route_e;
   typedef enum logic [1:0] {S_LISTED = 2'd0, S_OTHERS = 2'd1, S_SELF = 2'd2, S_NONE = 2'd3} sgi_e;
endpackage

// File: rtl/irqd_cell.sv
module irqd_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   input  logic eoi,
   output logic pend,
   output logic act
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         act  <= 1'b0;
      end else begin
         pend <= (pend & ~ack) | set;
         if (ack)      act <= 1'b1;
         else if (eoi) act <= 1'b0;
      end
   end
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int NID    = 64,
   parameter int PRIO_W = 4,
   parameter int ID_W   = 10
) (
   input  logic [NID-1:0]        cand,
   input  logic [NID*PRIO_W-1:0] prio,
   output logic                  hit,
   output logic [ID_W-1:0]       win
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      hit  = 1'b0;
      win  = '0;
      best = '1;
      for (int i = 0; i < NID; i++) begin
         if (cand[i] && (!hit || prio[i*PRIO_W +: PRIO_W] < best)) begin
            hit  = 1'b1;
            best = prio[i*PRIO_W +: PRIO_W];
            win  = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/mp_irq_distributor.sv
module mp_irq_distributor
   import irqd_pkg::*;
#(
   parameter int NCORE  = 4,
   parameter int NID    = 64,
   parameter int NSGI   = 16,
   parameter int PRIO_W = 4,
   localparam int CW    = $clog2(NCORE),
   localparam int IDX_W = $clog2(NID),
   localparam int NSHR  = NID - BANK_N,
   localparam int SW    = $clog2(NSHR),
   localparam int AW    = IDX_W + 2,
   localparam int DW    = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSHR-1:0]       hw_irq,
   input  logic [2*NCORE-1:0]    priv_irq,
   input  logic                  cfg_we,
   input  logic [CW-1:0]         cfg_core,
   input  logic [AW-1:0]         cfg_addr,
   input  logic [DW-1:0]         cfg_wdata,
   input  logic [NCORE-1:0]      ack_rd,
   input  logic [NCORE-1:0]      eoi_wr,
   input  logic [NCORE*ID_W-1:0] eoi_id,
   output logic [NCORE*ID_W-1:0] ack_id,
   output logic [NCORE-1:0]      irq_req
);
   if (NCORE < 2 || NCORE > 4) begin : g_bad_core
      $error("NCORE must be 2..4");
   end
   if (NID <= BANK_N || NID % BANK_N != 0 || NID > 1024) begin : g_bad_nid
      $error("NID must be a multiple of 32 above 32");
   end
   if (NSGI < 1 || NSGI > 16) begin : g_bad_sgi
      $error("NSGI must be 1..16");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("PRIO_W must be 1..4");
   end

   logic [NSHR-1:0]    hw_q,   hw_rise;
   logic [2*NCORE-1:0] priv_q, priv_rise;
   assign hw_rise   = hw_irq & ~hw_q;
   assign priv_rise = priv_irq & ~priv_q;

   kind_e            kind;
   logic [IDX_W-1:0] aid, sidx_full;
   logic [SW-1:0]    sidx;
   logic [BW-1:0]    bidx;
   logic             is_bank;
   assign kind      = kind_e'(cfg_addr[AW-1 -: 2]);
   assign aid       = cfg_addr[IDX_W-1:0];
   assign is_bank   = aid < IDX_W'(BANK_N);
   assign sidx_full = aid - IDX_W'(BANK_N);
   assign sidx      = sidx_full[SW-1:0];
   assign bidx      = aid[BW-1:0];

   logic [NCORE-1:0][BANK_N-1:0]             bank_en;
   logic [NCORE-1:0][BANK_N-1:0][PRIO_W-1:0] bank_prio;
   logic [NSHR-1:0]                          shr_en;
   logic [NSHR-1:0][PRIO_W-1:0]              shr_prio;
   logic [NSHR-1:0][NCORE-1:0]               shr_tgt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hw_q      <= '0;
         priv_q    <= '0;
         bank_en   <= '0;
         bank_prio <= '0;
         shr_en    <= '0;
         shr_prio  <= '0;
         for (int k = 0; k < NSHR; k++) shr_tgt[k] <= NCORE'(1);
      end else begin
         hw_q   <= hw_irq;
         priv_q <= priv_irq;
         if (cfg_we && kind == K_CFG) begin
            if (is_bank) begin
               bank_en[cfg_core][bidx]   <= cfg_wdata[0];
               bank_prio[cfg_core][bidx] <= cfg_wdata[4 +: PRIO_W];
            end else begin
               shr_en[sidx]   <= cfg_wdata[0];
               shr_prio[sidx] <= cfg_wdata[4 +: PRIO_W];
            end
         end
         if (cfg_we && kind == K_ROUTE && !is_bank) begin
            case (route_e'(cfg_wdata[1:0]))
               R_ONE:   shr_tgt[sidx] <= NCORE'(1) << cfg_wdata[4 +: CW];
               R_GROUP: shr_tgt[sidx] <= cfg_wdata[8 +: NCORE];
               R_ALL:   shr_tgt[sidx] <= '1;
               default: ;
            endcase
         end
      end
   end

   // software command decode: which cores receive the private copy
   logic [NCORE-1:0] sgi_hit;
   logic [3:0]       sgi_id;
   assign sgi_id = cfg_wdata[3:0];
   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         sgi_hit[c] = 1'b0;
         if (cfg_we && kind == K_SGI) begin
            case (sgi_e'(cfg_wdata[9:8]))
               S_LISTED: sgi_hit[c] = cfg_wdata[4 +: CW] == CW'(c);
               S_OTHERS: sgi_hit[c] = cfg_core != CW'(c);
               S_SELF:   sgi_hit[c] = cfg_core == CW'(c);
               default:  sgi_hit[c] = 1'b0;
            endcase
         end
      end
   end

   logic [NCORE-1:0][ID_W-1:0] win_id;
   logic [NCORE-1:0]           win_v, lost, take;
   logic [NCORE-1:0][BANK_N-1:0] bank_pend, bank_act;
   logic [NSHR-1:0] shr_pend, shr_act, shr_ack, shr_eoi;

   for (genvar c = 0; c < NCORE; c++) begin : g_core
      for (genvar i = 0; i < BANK_N; i++) begin : g_id
         if (i < NSGI || i == ID_TMR || i == ID_WDG) begin : g_cell
            logic set_i, ack_i, eoi_i;
            if (i < NSGI) begin : g_sgi
               assign set_i = sgi_hit[c] && sgi_id == 4'(i);
            end else if (i == ID_TMR) begin : g_tmr
               assign set_i = priv_rise[2*c];
            end else begin : g_wdg
               assign set_i = priv_rise[2*c+1];
            end
            assign ack_i = take[c] && win_id[c] == ID_W'(i);
            assign eoi_i = eoi_wr[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(i);
            irqd_cell u_cell (
               .clk(clk), .rst_n(rst_n), .set(set_i), .ack(ack_i), .eoi(eoi_i),
               .pend(bank_pend[c][i]), .act(bank_act[c][i])
            );
         end else begin : g_none
            assign bank_pend[c][i] = 1'b0;
            assign bank_act[c][i]  = 1'b0;
         end
      end
   end

   for (genvar k = 0; k < NSHR; k++) begin : g_shr
      logic [NCORE-1:0] am, em;
      for (genvar c = 0; c < NCORE; c++) begin : g_m
         assign am[c] = take[c] && win_id[c] == ID_W'(BANK_N + k);
         assign em[c] = eoi_wr[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(BANK_N + k);
      end
      assign shr_ack[k] = |am;
      assign shr_eoi[k] = |em;
      irqd_cell u_cell (
         .clk(clk), .rst_n(rst_n), .set(hw_rise[k]), .ack(shr_ack[k]), .eoi(shr_eoi[k]),
         .pend(shr_pend[k]), .act(shr_act[k])
      );
   end

   logic [NCORE-1:0][NID-1:0]        cand;
   logic [NCORE-1:0][NID*PRIO_W-1:0] cprio;
   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         for (int i = 0; i < NID; i++) begin
            if (i < BANK_N) begin
               cand[c][i] = bank_pend[c][i] & ~bank_act[c][i] & bank_en[c][i];
               cprio[c][i*PRIO_W +: PRIO_W] = bank_prio[c][i];
            end else begin
               cand[c][i] = shr_pend[i-BANK_N] & ~shr_act[i-BANK_N] &
                            shr_en[i-BANK_N] & shr_tgt[i-BANK_N][c];
               cprio[c][i*PRIO_W +: PRIO_W] = shr_prio[i-BANK_N];
            end
         end
      end
   end

   for (genvar c = 0; c < NCORE; c++) begin : g_pick
      irqd_pick #(.NID(NID), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
         .cand(cand[c]), .prio(cprio[c]), .hit(win_v[c]), .win(win_id[c])
      );
   end

   // a shared ID claimed by several cores in one cycle goes to the lowest core
   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         lost[c] = 1'b0;
         for (int d = 0; d < c; d++) begin
            if (ack_rd[d] && win_v[d] && win_id[d] == win_id[c] &&
                win_id[c] >= ID_W'(BANK_N))
               lost[c] = 1'b1;
         end
         take[c] = ack_rd[c] & win_v[c] & ~lost[c];
         ack_id[c*ID_W +: ID_W] = (win_v[c] && !lost[c]) ? win_id[c] : SPURIOUS;
      end
   end

   assign irq_req = win_v;
endmodule

// File: rtl/mp_irq_distributor_chk.sv
module mp_irq_distributor_chk
   import irqd_pkg::*;
#(
   parameter int NCORE = 4,
   parameter int NID   = 64,
   parameter int NSHR  = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NCORE-1:0]      ack_rd,
   input logic [NCORE-1:0]      irq_req,
   input logic [NCORE*ID_W-1:0] ack_id,
   input logic [NSHR-1:0]       shr_ack,
   input logic [NSHR-1:0]       shr_eoi,
   input logic [NSHR-1:0]       shr_pend,
   input logic [NSHR-1:0]       shr_act
);
   for (genvar c = 0; c < NCORE; c++) begin : g_c
      AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_req[c] |-> ack_id[c*ID_W +: ID_W] == SPURIOUS); // R1
      AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         ack_id[c*ID_W +: ID_W] == SPURIOUS || ack_id[c*ID_W +: ID_W] < ID_W'(NID)); // R5
      for (genvar d = c + 1; d < NCORE; d++) begin : g_d
         AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            !(ack_rd[c] && ack_rd[d] &&
              ack_id[c*ID_W +: ID_W] == ack_id[d*ID_W +: ID_W] &&
              ack_id[c*ID_W +: ID_W] >= ID_W'(BANK_N) &&
              ack_id[c*ID_W +: ID_W] != SPURIOUS)); // R10
      end
   end
   for (genvar k = 0; k < NSHR; k++) begin : g_k
      AST_ACK_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         shr_ack[k] |-> shr_pend[k] && !shr_act[k]); // R5
      AST_ACK_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
         shr_ack[k] |=> shr_act[k]); // R5
      AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         shr_eoi[k] && !shr_ack[k] |=> !shr_act[k]); // R6
   end
endmodule

bind mp_irq_distributor mp_irq_distributor_chk #(.NCORE(NCORE), .NID(NID), .NSHR(NSHR)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .irq_req(irq_req), .ack_id(ack_id),
   .shr_ack(shr_ack), .shr_eoi(shr_eoi), .shr_pend(shr_pend), .shr_act(shr_act)
);

// File: tb/mp_irq_distributor_test.sv
`timescale 1ns/1ps
module mp_irq_distributor_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] hw_irq;
   logic [7:0]  priv_irq;
   logic        cfg_we;
   logic [1:0]  cfg_core;
   logic [7:0]  cfg_addr;
   logic [11:0] cfg_wdata;
   logic [3:0]  ack_rd, eoi_wr, irq_req;
   logic [39:0] eoi_id, ack_id;
   int nchk = 0, nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mp_irq_distributor uut (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .priv_irq(priv_irq), .cfg_we(cfg_we),
      .cfg_core(cfg_core), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack_rd(ack_rd),
      .eoi_wr(eoi_wr), .eoi_id(eoi_id), .ack_id(ack_id), .irq_req(irq_req)
   );

   // {id_a, prio_a, id_b, prio_b, expected first}
   localparam logic [25:0] VEC [5] = '{
      {6'd33, 4'd3,  6'd34, 4'd7,  6'd33},
      {6'd36, 4'd9,  6'd35, 4'd2,  6'd35},
      {6'd38, 4'd4,  6'd37, 4'd4,  6'd37},
      {6'd63, 4'd0,  6'd62, 4'd1,  6'd63},
      {6'd60, 4'd15, 6'd39, 4'd15, 6'd39}
   };

   task automatic tick; @(posedge clk); #1; endtask

   task automatic check(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int idof(int c); return int'(ack_id[c*10 +: 10]); endfunction

   task automatic wr(logic [1:0] kind, int id, logic [11:0] d, int core);
      cfg_we = 1'b1; cfg_addr = {kind, 6'(id)}; cfg_wdata = d; cfg_core = 2'(core);
      tick;
      cfg_we = 1'b0;
   endtask
   task automatic cfgid(int id, bit en, int prio, int core);
      wr(2'd0, id, {4'd0, 4'(prio), 3'd0, en}, core);
   endtask
   task automatic route(int id, int mode, int core, logic [3:0] mask);
      wr(2'd1, id, {mask, 2'd0, 2'(core), 2'd0, 2'(mode)}, 0);
   endtask
   task automatic sgi(int req, int id, int filt, int tgt);
      wr(2'd2, 0, {2'd0, 2'(filt), 2'd0, 2'(tgt), 4'(id)}, req);
   endtask
   task automatic hw(int id);
      hw_irq[id-32] = 1'b1; tick; hw_irq[id-32] = 1'b0;
   endtask
   task automatic ackc(int c, int exp, string tag);
      ack_rd[c] = 1'b1; #1;
      check(tag, idof(c), exp);
      @(posedge clk); #1; ack_rd[c] = 1'b0;
   endtask
   task automatic eoi(int c, int id);
      eoi_wr[c] = 1'b1; eoi_id[c*10 +: 10] = 10'(id); tick; eoi_wr[c] = 1'b0;
   endtask
   task automatic idle_all(string tag);
      for (int c = 0; c < 4; c++) check(tag, idof(c), 1023);
   endtask

   initial begin
      #800000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      rst_n = 0; hw_irq = '0; priv_irq = '0; cfg_we = 0; cfg_core = 0; cfg_addr = 0;
      cfg_wdata = 0; ack_rd = 0; eoi_wr = 0; eoi_id = 0;
      repeat (3) tick;
      check("R1 req", int'(irq_req), 0);
      idle_all("R1");
      rst_n = 1; tick;

      // R2/R3 one core
      cfgid(40, 1, 5, 0); route(40, 0, 2, 4'd0); hw(40);
      check("R3 one core2", idof(2), 40);
      check("R3 one core0", idof(0), 1023);
      ackc(2, 40, "R5 claim"); eoi(2, 40);
      // R2 disabled stays waiting
      hw(41);
      check("R2 disabled", idof(0), 1023);
      cfgid(41, 1, 5, 0);
      check("R2 enabled later", idof(0), 41);
      ackc(0, 41, "R2"); eoi(0, 41);

      // R3 group + R10 concurrent claim
      cfgid(45, 1, 2, 0); route(45, 1, 0, 4'b1010); hw(45);
      check("R3 grp c1", idof(1), 45); check("R3 grp c3", idof(3), 45);
      check("R3 grp c0", idof(0), 1023); check("R3 grp c2", idof(2), 1023);
      ack_rd[1] = 1; ack_rd[3] = 1; #1;
      check("R10 low core", idof(1), 45);
      check("R10 high core", idof(3), 1023);
      tick; ack_rd = '0;
      check("R10 after", idof(3), 1023);
      eoi(1, 45);

      // R3 all, R6 re-raise while in service
      cfgid(50, 1, 1, 0); route(50, 2, 0, 4'd0); hw(50);
      for (int c = 0; c < 4; c++) check("R3 all", idof(c), 50);
      ackc(0, 50, "R5 all");
      hw(50);
      idle_all("R6 in service");
      eoi(0, 50);
      check("R6 again", idof(3), 50);
      ackc(3, 50, "R6"); eoi(3, 50);
      idle_all("R6 idle");

      // R4 priority table, R5 next candidate
      for (int e = 0; e < 5; e++) begin
         int a, b, x, o;
         a = int'(VEC[e][25:20]); b = int'(VEC[e][15:10]); x = int'(VEC[e][5:0]);
         o = (x == a) ? b : a;
         cfgid(a, 1, int'(VEC[e][19:16]), 0); cfgid(b, 1, int'(VEC[e][9:6]), 0);
         hw(a); hw(b);
         check("R4 req", int'(irq_req[0]), 1);
         ackc(0, x, "R4 winner");
         ackc(0, o, "R5 next");
         check("R5 empty", idof(0), 1023);
         eoi(0, a); eoi(0, b);
      end

      // R7 software filters
      for (int c = 0; c < 4; c++) cfgid(3, 1, 4, c);
      sgi(1, 3, 1, 0);
      check("R7 others self", idof(1), 1023);
      for (int c = 0; c < 4; c++) if (c != 1) begin ackc(c, 3, "R7 others"); eoi(c, 3); end
      sgi(2, 3, 2, 0);
      check("R7 self", idof(2), 3); check("R7 self c0", idof(0), 1023);
      ackc(2, 3, "R7"); eoi(2, 3);
      sgi(0, 3, 0, 3);
      check("R7 listed", idof(3), 3); check("R7 listed c0", idof(0), 1023);
      ackc(3, 3, "R7"); eoi(3, 3);

      // R8 target priority
      cfgid(3, 1, 9, 0); cfgid(7, 1, 1, 0);
      cfgid(3, 1, 0, 1); cfgid(7, 1, 15, 1);
      sgi(1, 3, 0, 0); sgi(1, 7, 0, 0);
      check("R8 winner", idof(0), 7);
      check("R8 issuer", idof(1), 1023);
      ackc(0, 7, "R8"); ackc(0, 3, "R8 next"); eoi(0, 7); eoi(0, 3);

      // R9 private
      cfgid(29, 1, 3, 2); priv_irq[4] = 1; tick; priv_irq[4] = 0;
      check("R9 tmr own", idof(2), 29); check("R9 tmr other", idof(3), 1023);
      ackc(2, 29, "R9"); eoi(2, 29);
      cfgid(30, 1, 3, 1); priv_irq[3] = 1; tick; priv_irq[3] = 0;
      check("R9 wdg own", idof(1), 30); check("R9 wdg other", idof(0), 1023);
      ackc(1, 30, "R9"); eoi(1, 30);
      idle_all("R6 final");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule